// File: doc/BRIEF.md
# Aligned Multi-Ratio Clock Divider Group

The block turns one fast source clock into five synchronous divided clocks. Each divided clock appears as a one-cycle enable pulse in the fast domain. All five share one phase counter, so every output rises on a power-of-two grid that starts at counter zero. The slowest output's boundary is therefore a point where the whole group rises at once.

Software writes a 10-bit control word through a value-plus-strobe port. The word sets a base divide code, two ratio selects for the derived outputs, and one software gate bit per output. Hardware sees the write and raises a busy flag. It holds the whole group gated off and waits for the last fast cycle of the slowest output's current period. In that cycle it loads the new ratios, so the next cycle is a common rising edge under the new setting. A write made while a change is still pending replaces the pending value, and the latest one wins. Because of this, no output ever produces a shortened period.

Top module: `clkdiv_group`

## Requirements
- R1: After reset, the base code is 0 and both selects are 0. All five gate bits are 1 and busy is 0. In the first cycle after reset, every output pulses.
- R2: The control word holds the base code in bits [2:0], selA in bit 3, selB in bit 4, and the gates in bits [9:5], with bit 5+i gating output i. Let b be the base code. Output i has log2 ratio l(i) = b+0, b+1, b+2, b+selA and b+2+selB for i = 0 to 4. Output i pulses in the fast cycles where the phase counter modulo 2^l(i) is 0.
- R3: With the group not busy, every output whose gate bit is set pulses in each cycle where the phase counter is 0. The phase counter runs from 0 to 2^(b+2+selB)-1 and then wraps.
- R4: Busy reads 1 in the cycle after any write. While busy is 1, no output pulses.
- R5: A pending setting takes effect at the first counter wrap after busy rises, on the last count of the slowest output's old period. Busy then clears. In the following cycle, all gated-on outputs pulse together under the new ratios. If the write arrives at phase p and the old last count is L, busy stays high for L-p cycles when p<L, and for L+1 cycles when p=L.
- R6: A write made while busy replaces the pending value. Only the last value written is applied, at the same boundary the earlier write was waiting for.
- R7: Base codes 5, 6 and 7 are treated as code 4 (divide by 16).
- R8: An output whose gate bit is 0 never pulses once the setting is applied. The other outputs are not affected.
- R9: A write made in the very cycle a pending setting is applied is queued. Busy stays 1, and the new value is applied at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 10 | Control word: base code, ratio selects, gate bits |
| busy | output | 1 | A new setting is pending |
| clkEn | output | 5 | Enable pulses of the five divided clocks |

## Verification
The bench sweeps every legal base code with both selects. It also covers the clamped codes, several gate patterns, a back-to-back overwrite while busy, and a write placed exactly on the apply cycle. Each case is compared cycle by cycle against an arithmetic phase model.

For the busy window, the number of busy cycles is predicted from the write phase. A design that loaded the new setting at the wrong count would produce a runt or stretched period, and would also show the wrong busy length. A design that let outputs run during the pause would show pulses while busy. A design that dropped the write on the apply cycle would clear busy too early.

// File: rtl/clkgrp_pkg.sv
package clkgrp_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_CODE = 4;
  localparam int NOUT     = 5;
  localparam int CNT_W    = MAX_CODE + 3;
  localparam int WR_W     = CODE_W + 2 + NOUT;

  typedef struct packed {
    logic [CODE_W-1:0] base;
    logic              selA;
    logic              selB;
  } ratio_t;

  typedef struct packed {
    logic load;
    logic hold;
  } strobe_t;

  function automatic logic [CODE_W-1:0] clampCode(input logic [CODE_W-1:0] code);
    return (int'(code) > MAX_CODE) ? CODE_W'(MAX_CODE) : code;
  endfunction

  // log2 ratio of output idx relative to the fast clock
  function automatic int outLog(input ratio_t r, input int idx);
    int l;
    l = int'(r.base);
    case (idx)
      1: l = l + 1;
      2: l = l + 2;
      3: l = l + int'(r.selA);
      4: l = l + 2 + int'(r.selB);
      default: l = l + 0;
    endcase
    return l;
  endfunction

  function automatic int slowLog(input ratio_t r);
    return outLog(r, NOUT - 1);
  endfunction
endpackage

// File: rtl/clkgrp_dp.sv
module clkgrp_dp
  import clkgrp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  ratio_t          nextCfg,
  input  logic [NOUT-1:0] gate,
  output logic            atLast,
  output logic [NOUT-1:0] clkEn
);
  ratio_t           cfg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W:0]   spanM1;

  always_comb begin
    spanM1  = ({{CNT_W{1'b0}}, 1'b1} << slowLog(cfg)) - 1'b1;
    lastCnt = spanM1[CNT_W-1:0];
  end

  assign atLast = (cnt == lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      cfg <= '0;
    end else begin
      cnt <= atLast ? '0 : cnt + 1'b1;
      if (stb.load) cfg <= nextCfg;
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    logic [CNT_W:0] maskW;
    always_comb maskW = ({{CNT_W{1'b0}}, 1'b1} << outLog(cfg, i)) - 1'b1;
    assign clkEn[i] = !stb.hold && gate[i] && ((cnt & maskW[CNT_W-1:0]) == '0);
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCnt); // R2
  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (cnt == '0)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(cfg)); // R6
  AST_JOINT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ((cnt == '0) && !stb.hold) |-> (clkEn == gate)); // R3
endmodule

// File: rtl/clkgrp_ctrl.sv
module clkgrp_ctrl
  import clkgrp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [WR_W-1:0] wrData,
  input  logic            atLast,
  output strobe_t         stb,
  output ratio_t          pendCfg,
  output logic [NOUT-1:0] gate,
  output logic            busy
);
  ratio_t          wrCfg;
  logic [NOUT-1:0] wrGate;

  always_comb begin
    wrCfg.base = clampCode(wrData[CODE_W-1:0]);
    wrCfg.selA = wrData[CODE_W];
    wrCfg.selB = wrData[CODE_W+1];
    wrGate     = wrData[WR_W-1:CODE_W+2];
    stb.load   = busy && atLast;
    stb.hold   = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      pendCfg <= '0;
      gate    <= '1;
    end else if (wrEn) begin
      pendCfg <= wrCfg;
      gate    <= wrGate;
      busy    <= 1'b1;
    end else if (stb.load) begin
      busy    <= 1'b0;
    end
  end

  AST_WR_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> busy); // R4
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !wrEn) |=> !busy); // R4
  AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !wrEn) |=> !busy); // R5
  AST_QUEUE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && wrEn) |=> busy); // R9
  AST_PEND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    int'(pendCfg.base) <= MAX_CODE); // R7
endmodule

// File: rtl/clkdiv_group.sv
module clkdiv_group
  import clkgrp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [WR_W-1:0] wrData,
  output logic            busy,
  output logic [NOUT-1:0] clkEn
);
  strobe_t         stb;
  ratio_t          pendCfg;
  logic [NOUT-1:0] gate;
  logic            atLast;

  clkgrp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .atLast(atLast),
    .stb(stb), .pendCfg(pendCfg), .gate(gate), .busy(busy)
  );

  clkgrp_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .nextCfg(pendCfg), .gate(gate),
    .atLast(atLast), .clkEn(clkEn)
  );
endmodule

// File: tb/sim_clkdiv_group.sv
`timescale 1ns/1ps
module sim_clkdiv_group;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [9:0] wrData = '0;
  logic       busy;
  logic [4:0] clkEn;

  always #2 clk = ~clk;

  clkdiv_group u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
                   .busy(busy), .clkEn(clkEn));

  int checks = 0;
  int failures = 0;
  int curBase = 0, curA = 0, curB = 0;
  int pBase = 0, pA = 0, pB = 0;
  logic [4:0] mGate = 5'h1f;
  bit mBusy = 0;
  int mPhase = 0;
  bit justApplied = 0;
  string curTag = "R2";

  function automatic int lg(int b, int a, int s, int i);
    case (i)
      0: return b;
      1: return b + 1;
      2: return b + 2;
      3: return b + a;
      default: return b + 2 + s;
    endcase
  endfunction

  function automatic int lastOf(int b, int s);
    return (1 << (b + 2 + s)) - 1;
  endfunction

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s phase=%0d actual=%0h expected=%0h", tag, mPhase, act, exp);
    end
  endtask

  task automatic checkNow();
    logic [4:0] e;
    string tag;
    for (int i = 0; i < 5; i++)
      e[i] = !mBusy && mGate[i] &&
             ((mPhase % (1 << lg(curBase, curA, curB, i))) == 0);
    if (mBusy) tag = "R4";
    else if (justApplied) tag = "R5";
    else if (mPhase == 0 && curTag == "R2") tag = "R3";
    else tag = curTag;
    checkVal(tag, int'(clkEn), int'(e));
    checkVal("R4", int'(busy), int'(mBusy));
  endtask

  task automatic step(bit wr, logic [9:0] d);
    int L;
    bit ap;
    int nph;
    checkNow();
    wrEn = wr;
    wrData = d;
    L = lastOf(curBase, curB);
    ap = mBusy && (mPhase == L);
    nph = (mPhase == L) ? 0 : mPhase + 1;
    if (ap) begin curBase = pBase; curA = pA; curB = pB; end
    if (wr) begin
      pBase = (int'(d[2:0]) > 4) ? 4 : int'(d[2:0]);
      pA = int'(d[3]);
      pB = int'(d[4]);
      mGate = d[9:5];
      mBusy = 1;
    end else if (ap) mBusy = 0;
    justApplied = ap && !wr;
    mPhase = nph;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic observe();
    repeat (2 * (lastOf(curBase, curB) + 1)) step(0, '0);
  endtask

  // write from idle, then measure the busy window against the phase formula
  task automatic doWrite(logic [9:0] d, string tag);
    int L, p, expN, n;
    L = lastOf(curBase, curB);
    p = mPhase;
    expN = (p < L) ? (L - p) : (L + 1);
    step(1, d);
    n = 0;
    while (busy && n < 300) begin
      n++;
      step(0, '0);
    end
    checkVal(tag, n, expN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    checkVal("R1", int'(clkEn), 31);
    checkVal("R1", int'(busy), 0);
    curTag = "R1";
    repeat (40) step(0, '0);

    // R2 / R3 / R5: sweep every legal code with both selects
    for (int b = 0; b <= 4; b++)
      for (int a = 0; a <= 1; a++)
        for (int s = 0; s <= 1; s++) begin
          curTag = "R2";
          repeat (b + a) step(0, '0);
          doWrite({5'h1f, 1'(s), 1'(a), 3'(b)}, "R5");
          observe();
        end

    // R7: out-of-range codes clamp to divide by 16
    for (int c = 5; c <= 7; c++) begin
      curTag = "R7";
      doWrite({5'h1f, 1'b0, 1'b1, 3'(c)}, "R7");
      observe();
      checkVal("R7", curBase, 4);
    end

    // R8: gate patterns
    begin
      logic [4:0] pats [3] = '{5'b10101, 5'b01010, 5'b00000};
      for (int k = 0; k < 3; k++) begin
        curTag = "R8";
        doWrite({pats[k], 2'b01, 3'd1}, "R8");
        observe();
      end
    end

    // R6: overwrite while busy, latest value wins
    curTag = "R6";
    repeat (3) step(0, '0);
    step(1, {5'h1f, 2'b00, 3'd2});
    step(1, {5'h1f, 2'b11, 3'd0});
    while (mBusy) step(0, '0);
    checkVal("R6", curBase, 0);
    checkVal("R6", curB, 1);
    observe();

    // R9: write landing on the apply cycle is queued
    curTag = "R9";
    step(1, {5'h1f, 2'b10, 3'd1});
    while (!(mBusy && mPhase == lastOf(curBase, curB))) step(0, '0);
    step(1, {5'h1f, 2'b01, 3'd0});
    checkVal("R9", int'(busy), 1);
    while (mBusy) step(0, '0);
    checkVal("R9", curA, 1);
    observe();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule